// File: doc/BRIEF.md
# Multi-Mode Segment Address Generator

This block turns a segment register choice and an offset into a linear address. It works in one of three operating modes, held in a small mode register. In the legacy real mode, the segment value is scaled by sixteen and added to a 16-bit offset. The result folds back into a 1 MiB window, and no protection is applied. In 16-bit protected mode, each segment carries a cached base and limit. The offset stays 16 bits, the address is 24 bits wide, and an offset beyond the limit raises a fault. In 64-bit flat mode, the four ordinary segments (code, stack, data, extra) see a zero base and no limit. The two auxiliary segments still add their cached base to a full 64-bit offset.

The six base/limit pairs live in registered descriptor caches. A single load port writes them. When the block is in real mode, a load derives the base and limit from the selector value. In any other mode, it takes the base and limit given on the port. The path from the access inputs to the address outputs is purely combinational. Loads and mode changes take effect on the following clock edge. Fetching descriptors from memory is left to the surrounding logic.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the mode is real (mode code 0), every cached base is 0 and every cached limit is 0xFFFF, so a real-mode access returns offset bits [15:0].
- R2: In real mode (code 0) with a valid segment index, the address is (base[19:0] + offset[15:0]) mod 2^20, zero-extended to 64 bits. Offset bits above 15 are ignored, and addr_vld_o is 1.
- R3: A real-mode sum above 0xFFFFF wraps to 0x00000 onward (selector 0xFFFF with offset 0x0010 gives address 0).
- R4: Real mode never raises fault_o for a valid segment index, whatever the offset or the cached limit.
- R5: A load issued while in real mode sets the chosen segment's base to selector × 16 and its limit to 0xFFFF. ld_base_i and ld_limit_i are ignored in that case.
- R6: In protected mode (code 1), when offset[15:0] ≤ limit, the address is (base[23:0] + offset[15:0]) mod 2^24, and addr_vld_o is 1.
- R7: In protected mode, offset[15:0] > limit sets fault_o to 1 and addr_vld_o to 0. An offset equal to the limit does not fault.
- R8: In 64-bit mode (code 2), segment indices 0..3 (code, stack, data, extra) produce address = offset_i, with no fault, whatever their cached base or limit.
- R9: In 64-bit mode, segment indices 4 and 5 produce address = (base + offset_i) mod 2^64, with no fault.
- R10: A segment index of 6 or 7, or mode code 3, gives fault_o=1, addr_vld_o=0 and addr_o=0. Whenever fault_o is 1, addr_o is 0.
- R11: A load issued outside real mode writes ld_base_i and ld_limit_i into the chosen segment. Loads and mode writes (mode_we_i) change outputs only from the next clock edge on. A load uses the mode in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Write enable for the mode register |
| mode_i | input | 2 | New mode: 0 real, 1 protected 16-bit, 2 flat 64-bit, 3 reserved |
| seg_idx_i | input | 3 | Segment used for the access: 0 code, 1 stack, 2 data, 3 extra, 4/5 auxiliary |
| offset_i | input | 64 | Access offset |
| ld_en_i | input | 1 | Descriptor cache load strobe |
| ld_idx_i | input | 3 | Segment written by a load |
| ld_sel_i | input | 16 | Selector value, used by real-mode loads |
| ld_base_i | input | 64 | Base, used by non-real-mode loads |
| ld_limit_i | input | 32 | Limit, used by non-real-mode loads |
| addr_o | output | 64 | Linear address |
| addr_vld_o | output | 1 | Address is usable |
| fault_o | output | 1 | Limit violation or illegal index or mode |
| mode_o | output | 2 | Current mode |

## Verification
The bench targets the two wrap points and the limit edge. A real-mode sum that spills past 20 bits would show up as a high address bit. A protected sum that spills past 24 bits would do the same. A less-than-or-equal compare done as strict less-than would fault on an offset exactly at the limit. The bench also checks that a real-mode load ignores the base and limit pins. A wrong design here would keep stale data or take the port base instead of the scaled selector. In 64-bit mode, a design that still applied the ordinary segments' bases would produce shifted addresses. A design that dropped the auxiliary bases would return the bare offset. Same-cycle checks after every load and mode write catch a design whose caches or mode act a cycle early.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int SEG_CNT  = 6;
    localparam int FLAT_CNT = 4;
    localparam int IDX_W    = 3;
    localparam int ADDR_W   = 64;
    localparam int SEL_W    = 16;
    localparam int LIM_W    = 32;
    localparam int SHORT_W  = 16;
    localparam int REAL_W   = 20;
    localparam int PROT_W   = 24;

    typedef enum logic [1:0] {
        MD_REAL = 2'd0,
        MD_PROT = 2'd1,
        MD_LONG = 2'd2,
        MD_RSVD = 2'd3
    } mode_e;
endpackage

// File: rtl/seg_mode_ctrl.sv
module seg_mode_ctrl
    import seg_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we_i,
    input  mode_e mode_i,
    output mode_e mode_o
);
    typedef struct packed {
        mode_e mode;
    } mstate_t;

    mstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.mode = mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MD_REAL};
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mode_o));
    // R11
    mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mode_o == $past(mode_i));
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import seg_addr_pkg::*;
#(
    parameter int N_SEG = SEG_CNT,
    parameter int IW    = IDX_W,
    parameter int BW    = ADDR_W,
    parameter int LW    = LIM_W,
    parameter int SW    = SEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      real_mode_i,
    input  logic                      ld_en_i,
    input  logic [IW-1:0]             ld_idx_i,
    input  logic [SW-1:0]             ld_sel_i,
    input  logic [BW-1:0]             ld_base_i,
    input  logic [LW-1:0]             ld_limit_i,
    output logic [N_SEG-1:0][BW-1:0]  base_o,
    output logic [N_SEG-1:0][LW-1:0]  lim_o
);
    localparam int PAD_B = BW - SW - 4;
    localparam int PAD_L = LW - SHORT_W;
    localparam logic [LW-1:0] REAL_LIM = {{PAD_L{1'b0}}, {SHORT_W{1'b1}}};

    typedef struct packed {
        logic [N_SEG-1:0][BW-1:0] base;
        logic [N_SEG-1:0][LW-1:0] lim;
    } cache_t;

    cache_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        for (int i = 0; i < N_SEG; i++) begin
            if (ld_en_i && ld_idx_i == IW'(i)) begin
                if (real_mode_i) begin
                    c_d.base[i] = {{PAD_B{1'b0}}, ld_sel_i, 4'h0};
                    c_d.lim[i]  = REAL_LIM;
                end else begin
                    c_d.base[i] = ld_base_i;
                    c_d.lim[i]  = ld_limit_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SEG; i++) begin
                c_q.base[i] <= '0;
                c_q.lim[i]  <= REAL_LIM;
            end
        end else begin
            c_q <= c_d;
        end
    end

    assign base_o = c_q.base;
    assign lim_o  = c_q.lim;

    // R11
    cache_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en_i |=> ($stable(base_o) && $stable(lim_o)));

    generate
        for (genvar g = 0; g < N_SEG; g++) begin : g_ent
            // R5
            real_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ld_en_i && real_mode_i && ld_idx_i == IW'(g)) |=>
                (base_o[g] == {{PAD_B{1'b0}}, $past(ld_sel_i), 4'h0} &&
                 lim_o[g] == REAL_LIM));
            // R11
            prot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ld_en_i && !real_mode_i && ld_idx_i == IW'(g)) |=>
                (base_o[g] == $past(ld_base_i) && lim_o[g] == $past(ld_limit_i)));
        end
    endgenerate
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
    import seg_addr_pkg::*;
#(
    parameter int N_SEG  = SEG_CNT,
    parameter int N_FLAT = FLAT_CNT,
    parameter int IW     = IDX_W,
    parameter int AW     = ADDR_W,
    parameter int LW     = LIM_W,
    parameter int RW     = REAL_W,
    parameter int PW     = PROT_W,
    parameter int OW     = SHORT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  mode_e                     mode_i,
    input  logic [IW-1:0]             seg_idx_i,
    input  logic [AW-1:0]             offset_i,
    input  logic [N_SEG-1:0][AW-1:0]  base_i,
    input  logic [N_SEG-1:0][LW-1:0]  lim_i,
    output logic [AW-1:0]             addr_o,
    output logic                      addr_vld_o,
    output logic                      fault_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          vld;
        logic          fault;
    } res_t;

    res_t          res;
    logic [AW-1:0] sel_base;
    logic [LW-1:0] sel_lim;
    logic          idx_ok;
    logic          flat_seg;
    logic [OW-1:0] off16;
    logic [RW-1:0] real_sum;
    logic [PW-1:0] prot_sum;
    logic [AW-1:0] long_sum;
    logic          over;

    always_comb begin
        sel_base = '0;
        sel_lim  = '0;
        for (int i = 0; i < N_SEG; i++) begin
            if (seg_idx_i == IW'(i)) begin
                sel_base = base_i[i];
                sel_lim  = lim_i[i];
            end
        end
        idx_ok   = seg_idx_i < IW'(N_SEG);
        flat_seg = seg_idx_i < IW'(N_FLAT);
        off16    = offset_i[OW-1:0];
        real_sum = sel_base[RW-1:0] + RW'(off16);
        prot_sum = sel_base[PW-1:0] + PW'(off16);
        long_sum = (flat_seg ? '0 : sel_base) + offset_i;
        over     = {{(LW-OW){1'b0}}, off16} > sel_lim;

        res = '{addr: '0, vld: 1'b0, fault: 1'b1};
        if (idx_ok) begin
            unique case (mode_i)
                MD_REAL: res = '{addr: AW'(real_sum), vld: 1'b1, fault: 1'b0};
                MD_PROT: begin
                    if (over) res = '{addr: '0, vld: 1'b0, fault: 1'b1};
                    else      res = '{addr: AW'(prot_sum), vld: 1'b1, fault: 1'b0};
                end
                MD_LONG: res = '{addr: long_sum, vld: 1'b1, fault: 1'b0};
                default: res = '{addr: '0, vld: 1'b0, fault: 1'b1};
            endcase
        end
    end

    assign addr_o     = res.addr;
    assign addr_vld_o = res.vld;
    assign fault_o    = res.fault;

    // R2
    real_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_REAL && seg_idx_i < IW'(N_SEG)) |->
        (addr_o[AW-1:RW] == '0 && addr_vld_o));
    // R4
    real_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_REAL && seg_idx_i < IW'(N_SEG)) |-> !fault_o);
    // R6
    prot_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_PROT && !fault_o) |-> addr_o[AW-1:PW] == '0);
    // R8
    long_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_LONG && seg_idx_i < IW'(N_FLAT)) |->
        (addr_o == offset_i && !fault_o));
    // R10
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (addr_o == '0 && !addr_vld_o));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int N_SEG = SEG_CNT,
    parameter int IW    = IDX_W,
    parameter int AW    = ADDR_W,
    parameter int LW    = LIM_W,
    parameter int SW    = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_we_i,
    input  logic [1:0]    mode_i,
    input  logic [IW-1:0] seg_idx_i,
    input  logic [AW-1:0] offset_i,
    input  logic          ld_en_i,
    input  logic [IW-1:0] ld_idx_i,
    input  logic [SW-1:0] ld_sel_i,
    input  logic [AW-1:0] ld_base_i,
    input  logic [LW-1:0] ld_limit_i,
    output logic [AW-1:0] addr_o,
    output logic          addr_vld_o,
    output logic          fault_o,
    output logic [1:0]    mode_o
);
    mode_e                    cur_mode;
    logic [N_SEG-1:0][AW-1:0] bases;
    logic [N_SEG-1:0][LW-1:0] limits;

    seg_mode_ctrl u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (mode_we_i),
        .mode_i (mode_e'(mode_i)),
        .mode_o (cur_mode)
    );

    seg_desc_cache #(
        .N_SEG(N_SEG), .IW(IW), .BW(AW), .LW(LW), .SW(SW)
    ) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .real_mode_i (cur_mode == MD_REAL),
        .ld_en_i     (ld_en_i),
        .ld_idx_i    (ld_idx_i),
        .ld_sel_i    (ld_sel_i),
        .ld_base_i   (ld_base_i),
        .ld_limit_i  (ld_limit_i),
        .base_o      (bases),
        .lim_o       (limits)
    );

    seg_addr_calc #(
        .N_SEG(N_SEG), .IW(IW), .AW(AW), .LW(LW)
    ) u_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (cur_mode),
        .seg_idx_i  (seg_idx_i),
        .offset_i   (offset_i),
        .base_i     (bases),
        .lim_i      (limits),
        .addr_o     (addr_o),
        .addr_vld_o (addr_vld_o),
        .fault_o    (fault_o)
    );

    assign mode_o = cur_mode;
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [2:0]  seg_idx_i = 3'd0;
    logic [63:0] offset_i = 64'd0;
    logic        ld_en_i = 1'b0;
    logic [2:0]  ld_idx_i = 3'd0;
    logic [15:0] ld_sel_i = 16'd0;
    logic [63:0] ld_base_i = 64'd0;
    logic [31:0] ld_limit_i = 32'd0;
    logic [63:0] addr_o;
    logic        addr_vld_o;
    logic        fault_o;
    logic [1:0]  mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    longint unsigned base_m [6];
    longint unsigned lim_m  [6];
    int              mode_m;

    always #10 clk = ~clk;

    seg_addr_gen u0 (.*);

    task automatic chk(string tag, longint unsigned act, longint unsigned exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic reset_model();
        for (int i = 0; i < 6; i++) begin
            base_m[i] = 0;
            lim_m[i]  = 64'hFFFF;
        end
        mode_m = 0;
    endtask

    // One cycle: inputs already set after a falling edge; compare, then clock the model.
    task automatic step(string tag);
        longint unsigned ea;
        bit ev, ef;
        longint unsigned o16;
        int idx;
        #5;
        idx = int'(seg_idx_i);
        o16 = offset_i & 64'hFFFF;
        ea = 0; ev = 0; ef = 1;
        if (mode_m != 3 && idx < 6) begin
            case (mode_m)
                0: begin ea = ((base_m[idx] & 64'hFFFFF) + o16) & 64'hFFFFF; ev = 1; ef = 0; end
                1: begin
                    if (o16 > lim_m[idx]) begin ea = 0; ev = 0; ef = 1; end
                    else begin ea = ((base_m[idx] & 64'hFFFFFF) + o16) & 64'hFFFFFF; ev = 1; ef = 0; end
                end
                default: begin ea = ((idx < 4) ? 64'd0 : base_m[idx]) + offset_i; ev = 1; ef = 0; end
            endcase
        end
        chk(tag, addr_o, ea, "addr");
        chk(tag, longint'(addr_vld_o), longint'(ev), "vld");
        chk(tag, longint'(fault_o), longint'(ef), "fault");
        chk(tag, longint'(mode_o), longint'(mode_m), "mode");
        @(posedge clk);
        if (ld_en_i && ld_idx_i < 3'd6) begin
            if (mode_m == 0) begin
                base_m[ld_idx_i] = longint'(ld_sel_i) << 4;
                lim_m[ld_idx_i]  = 64'hFFFF;
            end else begin
                base_m[ld_idx_i] = ld_base_i;
                lim_m[ld_idx_i]  = longint'(ld_limit_i);
            end
        end
        if (mode_we_i) mode_m = int'(mode_i);
        @(negedge clk);
        ld_en_i = 0;
        mode_we_i = 0;
    endtask

    task automatic acc(string tag, logic [2:0] idx, logic [63:0] off);
        seg_idx_i = idx;
        offset_i  = off;
        step(tag);
    endtask

    task automatic load(string tag, logic [2:0] idx, logic [15:0] sel, logic [63:0] b, logic [31:0] l);
        ld_en_i = 1; ld_idx_i = idx; ld_sel_i = sel; ld_base_i = b; ld_limit_i = l;
        step(tag);
    endtask

    task automatic set_mode(string tag, logic [1:0] m);
        mode_we_i = 1; mode_i = m;
        step(tag);
    endtask

    initial begin
        reset_model();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state: identity in the low 16 bits
        for (int i = 0; i < 6; i++) acc("R1", 3'(i), 64'h1234);
        // R2 upper offset bits ignored
        acc("R2", 3'd0, 64'hABCD_0000_0001_2345);
        // R5 real load ignores base/limit pins; R11 same-cycle output unchanged
        seg_idx_i = 3'd2; offset_i = 64'h22;
        load("R11", 3'd2, 16'h1234, 64'hDEAD_BEEF, 32'h10);
        acc("R2", 3'd2, 64'h22);
        // R3 wrap of the 20-bit window
        load("R5", 3'd3, 16'hFFFF, 64'h5555, 32'h1);
        acc("R3", 3'd3, 64'h10);
        acc("R3", 3'd3, 64'hFFFF);
        // R4 no fault in real mode
        acc("R4", 3'd2, 64'hFFFF);
        // R11 mode write visible next cycle only
        seg_idx_i = 3'd2; offset_i = 64'hFFFF;
        set_mode("R11", 2'd1);
        // R5 segment loaded in real mode keeps scaled base and full limit
        acc("R5", 3'd2, 64'hFFFF);
        acc("R7", 3'd3, 64'hFFFF);
        // R11 protected-mode loads
        load("R11", 3'd1, 16'h0, 64'hFF_F000, 32'h100);
        acc("R7", 3'd1, 64'h100);
        acc("R7", 3'd1, 64'h101);
        acc("R6", 3'd1, 64'h55);
        load("R11", 3'd0, 16'h0, 64'h1_0000_0500, 32'hFFFF);
        acc("R6", 3'd0, 64'h10);
        load("R11", 3'd1, 16'h0, 64'hFF_FFF0, 32'hFFFF);
        acc("R6", 3'd1, 64'h20);
        acc("R6", 3'd1, 64'hFFFF_0000_0000_0030);
        // R10 illegal index
        acc("R10", 3'd6, 64'h10);
        acc("R10", 3'd7, 64'h10);
        // R10 reserved mode
        set_mode("R10", 2'd3);
        acc("R10", 3'd0, 64'h10);
        // R8 / R9 flat 64-bit
        set_mode("R8", 2'd2);
        acc("R8", 3'd0, 64'hFFFF_FFFF_0000_1234);
        acc("R8", 3'd1, 64'h0000_0000_00FF_0000);
        acc("R8", 3'd3, 64'h8000_0000_0000_0001);
        load("R11", 3'd4, 16'h0, 64'h7FFF_0000_0000_0000, 32'h0);
        load("R11", 3'd5, 16'h0, 64'hFFFF_FFFF_FFFF_FFF0, 32'h0);
        acc("R9", 3'd4, 64'h0000_0000_0001_0000);
        acc("R9", 3'd5, 64'h20);
        acc("R10", 3'd6, 64'h20);
        // back to real: low 20 bits of a protected base are reused
        set_mode("R2", 2'd0);
        acc("R3", 3'd1, 64'h20);
        acc("R4", 3'd0, 64'hFFFF);
        // R1 reset again restores defaults
        rst_n = 0;
        reset_model();
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        acc("R1", 3'd4, 64'h00AB_CDEF);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule